// File: doc/BRIEF.md
# Chained Microsecond Free-Running Timer

The block contains two down-counting timer stages: a 24-bit low stage and a 32-bit high stage. Each stage counts on one tick input, chosen per stage from a small vector of tick-enable inputs. The system clock drives everything, and the ticks only qualify its edges. Used on its own, a stage counts down from its setting. When it reaches zero it reloads and reports a terminal count.

Setting the chain bit in the low stage's control word links the stages. The high stage then steps once for every low-stage terminal count. With a low setting of 7 and an 8 MHz tick, this gives one step per microsecond. In chained mode the high stage presents the bitwise inverse of its internal count, so the observed value rises. Software sets a start time T by loading all-ones minus T into the high setting and then pulsing the low stage's reload bit.

When the chained value passes all-ones, the high stage wraps to the inverse of its setting. It also raises a one-cycle interrupt pulse, which sets a sticky status bit. Software clears that bit by writing a 1 to it.

Top module: `usec_chain_timer`

## Requirements
- R1: After synchronous reset, all of the following are zero: counters, settings, tick selects, control bits, both observation outputs, `low_tc_o`, `irq_pulse_o` and `irq_status_o`.
- R2: Control word bit 0 enables a stage. An enabled stage acts on each clock where its selected tick (`src_tick_i[sel]`, sel written at register code 2) is high. At nonzero it decrements. At zero it reloads its setting (register code 1), and for the low stage `low_tc_o` pulses for one cycle on the following cycle. The period is therefore setting+1 ticks.
- R3: Bit 3 of the low control word selects chained mode. In chained mode the high stage, if enabled, steps once per low terminal count and ignores its own tick. `low_obs_o` then reads the low setting instead of the count.
- R4: In chained mode `high_obs_o` is the bitwise inverse of the internal high count, so each step raises it by one. A setting of 0xFFFFFFFF reads back as 0.
- R5: When a step reaches a high count of zero (chained reading 0xFFFFFFFF), the high stage reloads. In chained mode the reading becomes the inverse of the setting. `irq_pulse_o` is high for exactly the next cycle.
- R6: Writing control with bit 1 set (self-clearing) reloads that stage from its setting one cycle after the write. The reload takes priority over a tick in that cycle and produces no terminal count. The low stage's reload bit also reloads the high stage while chained mode is set. The sequence "high setting = 0xFFFFFFFF−T, then low reload" makes the reading T.
- R7: `irq_status_o` is set whenever `irq_pulse_o` is set. Writing register code 3 to the high stage with data bit 0 = 1 clears it. If a high terminal count falls in the same cycle as the clear write, the status stays set.
- R8: A stage whose enable bit is 0 holds its count whatever its tick does.
- R9: When chained mode is off, the high stage counts on its own selected tick, `high_obs_o` shows the count without inversion, and its terminal count still raises the interrupt.
- R10: Writing a new setting leaves a running count unchanged. The new value applies only at the next reload or terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | NSRC (4) | Tick-enable inputs selectable per stage |
| wr_en_i | input | 1 | Register write strobe |
| wr_stage_i | input | 1 | Target stage: 0 low, 1 high |
| wr_reg_i | input | 2 | Register code: 0 control, 1 setting, 2 tick select, 3 status clear |
| wr_data_i | input | HI_W (32) | Write data |
| low_obs_o | output | LO_W (24) | Low stage observation value |
| high_obs_o | output | HI_W (32) | High stage observation value |
| low_tc_o | output | 1 | Low stage terminal-count pulse |
| irq_pulse_o | output | 1 | High stage overflow / terminal-count pulse |
| irq_status_o | output | 1 | Sticky interrupt status |

## Verification
Two collisions can happen in a single clock, and the bench forces both.

The first is a high-stage terminal count landing in the same cycle as a status-clear write. The bench runs the high stage with a setting of 0 on an always-high tick, so a terminal count occurs every cycle, and then issues the clear. The status must stay set, and it must clear once the stage is disabled.

The second is a reload strobe landing in the same cycle as a tick. On an always-high tick, the first reading after the reload must equal the setting exactly, not one below it.

A behavioural model in the bench predicts every output on every clock, including during a phase of random register writes.

// File: rtl/uct_pkg.sv
package uct_pkg;

    localparam int unsigned LO_W_DEF  = 24;
    localparam int unsigned HI_W_DEF  = 32;
    localparam int unsigned NSRC_DEF  = 4;

    // register codes on wr_reg_i
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SET  = 2'd1,
        REG_SRC  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_RELOAD = 1;
    localparam int unsigned BIT_CHAIN  = 3;
    localparam int unsigned BIT_CLR    = 0;

    localparam logic STAGE_LO = 1'b0;
    localparam logic STAGE_HI = 1'b1;

    function automatic logic reg_hit(input logic en, input logic stage,
                                     input reg_sel_e code,
                                     input logic want_stage,
                                     input reg_sel_e want_code);
        return en && (stage == want_stage) && (code == want_code);
    endfunction

endpackage

// File: rtl/uct_regs.sv
module uct_regs
    import uct_pkg::*;
#(
    parameter int unsigned LO_W  = LO_W_DEF,
    parameter int unsigned HI_W  = HI_W_DEF,
    parameter int unsigned NSRC  = NSRC_DEF,
    localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic             wr_stage_i,
    input  logic [1:0]       wr_reg_i,
    input  logic [HI_W-1:0]  wr_data_i,
    output logic             lo_en_o,
    output logic             lo_chain_o,
    output logic             lo_rst_o,
    output logic [LO_W-1:0]  lo_set_o,
    output logic [SEL_W-1:0] lo_src_o,
    output logic             hi_en_o,
    output logic             hi_rst_o,
    output logic [HI_W-1:0]  hi_set_o,
    output logic [SEL_W-1:0] hi_src_o,
    output logic             stat_clr_o
);

    reg_sel_e code;
    assign code = reg_sel_e'(wr_reg_i);

    logic lo_ctrl_wr, hi_ctrl_wr, lo_set_wr, hi_set_wr, lo_src_wr, hi_src_wr;
    assign lo_ctrl_wr = reg_hit(wr_en_i, wr_stage_i, code, STAGE_LO, REG_CTRL);
    assign hi_ctrl_wr = reg_hit(wr_en_i, wr_stage_i, code, STAGE_HI, REG_CTRL);
    assign lo_set_wr  = reg_hit(wr_en_i, wr_stage_i, code, STAGE_LO, REG_SET);
    assign hi_set_wr  = reg_hit(wr_en_i, wr_stage_i, code, STAGE_HI, REG_SET);
    assign lo_src_wr  = reg_hit(wr_en_i, wr_stage_i, code, STAGE_LO, REG_SRC);
    assign hi_src_wr  = reg_hit(wr_en_i, wr_stage_i, code, STAGE_HI, REG_SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_en_o    <= 1'b0;
            lo_chain_o <= 1'b0;
            lo_rst_o   <= 1'b0;
            lo_set_o   <= '0;
            lo_src_o   <= '0;
            hi_en_o    <= 1'b0;
            hi_rst_o   <= 1'b0;
            hi_set_o   <= '0;
            hi_src_o   <= '0;
        end else begin
            lo_rst_o <= 1'b0;
            hi_rst_o <= 1'b0;
            if (lo_ctrl_wr) begin
                lo_en_o    <= wr_data_i[BIT_EN];
                lo_chain_o <= wr_data_i[BIT_CHAIN];
                lo_rst_o   <= wr_data_i[BIT_RELOAD];
            end
            if (hi_ctrl_wr) begin
                hi_en_o  <= wr_data_i[BIT_EN];
                hi_rst_o <= wr_data_i[BIT_RELOAD];
            end
            if (lo_set_wr) lo_set_o <= wr_data_i[LO_W-1:0];
            if (hi_set_wr) hi_set_o <= wr_data_i;
            if (lo_src_wr) lo_src_o <= wr_data_i[SEL_W-1:0];
            if (hi_src_wr) hi_src_o <= wr_data_i[SEL_W-1:0];
        end
    end

    assign stat_clr_o = reg_hit(wr_en_i, wr_stage_i, code, STAGE_HI, REG_STAT)
                        && wr_data_i[BIT_CLR];

    // R6: reload strobe lasts one cycle unless rewritten
    a_r6_strobe_clears: assert property (@(posedge clk) disable iff (rst)
        (lo_rst_o && !lo_ctrl_wr) |=> !lo_rst_o);

endmodule

// File: rtl/uct_stage.sv
module uct_stage
    import uct_pkg::*;
#(
    parameter int unsigned W     = HI_W_DEF,
    parameter int unsigned NSRC  = NSRC_DEF,
    localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    input  logic             chain_i,
    input  logic             chain_step_i,
    input  logic             reload_i,
    input  logic [W-1:0]     set_i,
    output logic [W-1:0]     cnt_o,
    output logic             event_o
);

    logic tick;
    generate
        if (NSRC > 1) begin : g_sel
            assign tick = src_i[sel_i];
        end else begin : g_single
            logic unused_sel;
            assign unused_sel = ^sel_i;
            assign tick = src_i[0];
        end
    endgenerate

    logic step;
    logic at_zero;
    logic [W-1:0] cnt_q;

    assign step    = en_i && (chain_i ? chain_step_i : tick);
    assign at_zero = (cnt_q == '0);
    assign event_o = step && at_zero && !reload_i;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= set_i;
        end else if (step) begin
            cnt_q <= at_zero ? set_i : cnt_q - 1'b1;
        end
    end

    // R8: no step and no reload means the count holds
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && !step) |=> $stable(cnt_q));

    // R6: a reload loads the setting seen at that edge
    a_r6_reload_value: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> (cnt_q == $past(set_i)));

    // R2: terminal count reloads the setting
    a_r2_wrap_to_set: assert property (@(posedge clk) disable iff (rst)
        event_o |=> (cnt_q == $past(set_i)));

endmodule

// File: rtl/uct_irq.sv
module uct_irq (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic clr_i,
    output logic pulse_o,
    output logic status_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o  <= 1'b0;
            status_o <= 1'b0;
        end else begin
            pulse_o  <= event_i;
            status_o <= (status_o && !clr_i) || event_i;
        end
    end

    // R7: a terminal count wins over a clear in the same cycle
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        event_i |=> status_o);

    // R7: a clear with no competing event empties the status
    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !event_i) |=> !status_o);

    // R7: the pulse is always reflected in the status
    a_r7_pulse_in_status: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> status_o);

endmodule

// File: rtl/usec_chain_timer.sv
module usec_chain_timer
    import uct_pkg::*;
#(
    parameter int unsigned LO_W  = LO_W_DEF,
    parameter int unsigned HI_W  = HI_W_DEF,
    parameter int unsigned NSRC  = NSRC_DEF,
    localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_tick_i,
    input  logic            wr_en_i,
    input  logic            wr_stage_i,
    input  logic [1:0]      wr_reg_i,
    input  logic [HI_W-1:0] wr_data_i,
    output logic [LO_W-1:0] low_obs_o,
    output logic [HI_W-1:0] high_obs_o,
    output logic            low_tc_o,
    output logic            irq_pulse_o,
    output logic            irq_status_o
);

    logic             lo_en, lo_chain, lo_rst, hi_en, hi_rst, stat_clr;
    logic [LO_W-1:0]  lo_set, lo_cnt;
    logic [HI_W-1:0]  hi_set, hi_cnt;
    logic [SEL_W-1:0] lo_src, hi_src;
    logic             lo_event, hi_event, hi_reload;

    uct_regs #(.LO_W(LO_W), .HI_W(HI_W), .NSRC(NSRC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_stage_i (wr_stage_i),
        .wr_reg_i   (wr_reg_i),
        .wr_data_i  (wr_data_i),
        .lo_en_o    (lo_en),
        .lo_chain_o (lo_chain),
        .lo_rst_o   (lo_rst),
        .lo_set_o   (lo_set),
        .lo_src_o   (lo_src),
        .hi_en_o    (hi_en),
        .hi_rst_o   (hi_rst),
        .hi_set_o   (hi_set),
        .hi_src_o   (hi_src),
        .stat_clr_o (stat_clr)
    );

    uct_stage #(.W(LO_W), .NSRC(NSRC)) u_low (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src_tick_i),
        .sel_i        (lo_src),
        .en_i         (lo_en),
        .chain_i      (1'b0),
        .chain_step_i (1'b0),
        .reload_i     (lo_rst),
        .set_i        (lo_set),
        .cnt_o        (lo_cnt),
        .event_o      (lo_event)
    );

    // low reload also restarts the high stage while chained
    assign hi_reload = hi_rst || (lo_rst && lo_chain);

    uct_stage #(.W(HI_W), .NSRC(NSRC)) u_high (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src_tick_i),
        .sel_i        (hi_src),
        .en_i         (hi_en),
        .chain_i      (lo_chain),
        .chain_step_i (lo_event),
        .reload_i     (hi_reload),
        .set_i        (hi_set),
        .cnt_o        (hi_cnt),
        .event_o      (hi_event)
    );

    uct_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .event_i  (hi_event),
        .clr_i    (stat_clr),
        .pulse_o  (irq_pulse_o),
        .status_o (irq_status_o)
    );

    always_ff @(posedge clk) begin
        if (rst) low_tc_o <= 1'b0;
        else     low_tc_o <= lo_event;
    end

    assign low_obs_o  = lo_chain ? lo_set : lo_cnt;
    assign high_obs_o = lo_chain ? ~hi_cnt : hi_cnt;

    // R4: a chained step with no wrap raises the reading by one
    a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
        (lo_chain && hi_en && lo_event && !hi_reload && (hi_cnt != '0) && !wr_en_i)
        |=> (high_obs_o == $past(high_obs_o) + 1'b1));

    // R5: a chained wrap shows the inverse of the setting
    a_r5_wrap_value: assert property (@(posedge clk) disable iff (rst)
        (lo_chain && hi_event && !wr_en_i) |=> (high_obs_o == ~$past(hi_set)));

    // R2: low terminal count is reported on the next cycle
    a_r2_low_tc: assert property (@(posedge clk) disable iff (rst)
        lo_event |=> low_tc_o);

endmodule

// File: tb/usec_chain_timer_test.sv
module usec_chain_timer_test;

    localparam int LO_W = 24;
    localparam int HI_W = 32;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            wr_en = 1'b0;
    logic            wr_stage = 1'b0;
    logic [1:0]      wr_reg = '0;
    logic [HI_W-1:0] wr_data = '0;
    logic [LO_W-1:0] low_obs;
    logic [HI_W-1:0] high_obs;
    logic            low_tc, irq_pulse, irq_status;

    always #10 clk = ~clk;   // 50 MHz

    usec_chain_timer #(.LO_W(LO_W), .HI_W(HI_W), .NSRC(NSRC)) uut (
        .clk          (clk),
        .rst          (rst),
        .src_tick_i   (src),
        .wr_en_i      (wr_en),
        .wr_stage_i   (wr_stage),
        .wr_reg_i     (wr_reg),
        .wr_data_i    (wr_data),
        .low_obs_o    (low_obs),
        .high_obs_o   (high_obs),
        .low_tc_o     (low_tc),
        .irq_pulse_o  (irq_pulse),
        .irq_status_o (irq_status)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // tick patterns: always, every third, every fifth, pseudo-random
    always @(negedge clk) begin
        cyc++;
        src[0] <= 1'b1;
        src[1] <= (cyc % 3) == 0;
        src[2] <= (cyc % 5) == 1;
        src[3] <= 1'($urandom & 1);
    end

    // behavioural reference model
    logic [23:0] m_lcnt, m_lset;
    logic [31:0] m_hcnt, m_hset;
    logic        m_len, m_hen, m_comb, m_lrp, m_hrp, m_irq, m_sts, m_ltc;
    logic [1:0]  m_lsrc, m_hsrc;

    always @(posedge clk) begin
        if (rst) begin
            m_lcnt = 0; m_lset = 0; m_hcnt = 0; m_hset = 0;
            m_len = 0; m_hen = 0; m_comb = 0; m_lrp = 0; m_hrp = 0;
            m_irq = 0; m_sts = 0; m_ltc = 0; m_lsrc = 0; m_hsrc = 0;
        end else begin
            logic lt, ht, lev, hrl, hadv, hev, clr;
            logic [23:0] nl;
            logic [31:0] nh;
            lt = src[m_lsrc];
            ht = src[m_hsrc];
            lev = m_len && lt && (m_lcnt == 0) && !m_lrp;
            if (m_lrp) nl = m_lset;
            else if (m_len && lt) nl = (m_lcnt == 0) ? m_lset : m_lcnt - 1;
            else nl = m_lcnt;
            hrl = m_hrp || (m_lrp && m_comb);
            hadv = m_hen && (m_comb ? lev : ht);
            hev = hadv && (m_hcnt == 0) && !hrl;
            if (hrl) nh = m_hset;
            else if (hadv) nh = (m_hcnt == 0) ? m_hset : m_hcnt - 1;
            else nh = m_hcnt;
            clr = wr_en && wr_stage && (wr_reg == 2'd3) && wr_data[0];
            m_sts = (m_sts && !clr) || hev;
            m_irq = hev;
            m_ltc = lev;
            m_lrp = 0;
            m_hrp = 0;
            if (wr_en) begin
                case (wr_reg)
                    2'd0: if (wr_stage) begin m_hen = wr_data[0]; m_hrp = wr_data[1]; end
                          else begin m_len = wr_data[0]; m_lrp = wr_data[1]; m_comb = wr_data[3]; end
                    2'd1: if (wr_stage) m_hset = wr_data; else m_lset = wr_data[23:0];
                    2'd2: if (wr_stage) m_hsrc = wr_data[1:0]; else m_lsrc = wr_data[1:0];
                    default: ;
                endcase
            end
            m_lcnt = nl;
            m_hcnt = nh;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R2/R3 low_obs", 32'(low_obs), 32'(m_comb ? m_lset : m_lcnt));
            check("R4/R9 high_obs", high_obs, m_comb ? ~m_hcnt : m_hcnt);
            check("R2 low_tc", 32'(low_tc), 32'(m_ltc));
            check("R5 irq_pulse", 32'(irq_pulse), 32'(m_irq));
            check("R7 irq_status", 32'(irq_status), 32'(m_sts));
        end
    end

    task automatic wr(input logic stg, input logic [1:0] r, input logic [31:0] d);
        wr_en = 1'b1; wr_stage = stg; wr_reg = r; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_main();
        logic [31:0] prev;
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 low_obs after reset", 32'(low_obs), 0);
        check("R1 high_obs after reset", high_obs, 0);
        check("R1 status after reset", 32'(irq_status), 0);

        // standalone low stage on the always-high tick
        wr(0, 2, 0);
        wr(0, 1, 3);
        wr(0, 0, 32'h3);
        @(negedge clk);
        check("R6 reload beats tick", 32'(low_obs), 3);
        repeat (3) @(negedge clk);
        check("R2 low reaches zero", 32'(low_obs), 0);
        @(negedge clk);
        check("R2 low wraps to setting", 32'(low_obs), 3);
        check("R2 low_tc pulse", 32'(low_tc), 1);
        wr(0, 1, 9);
        check("R10 setting write keeps count", 32'(low_obs), 2);
        wr(0, 0, 0);
        repeat (5) @(negedge clk);
        check("R8 disabled low holds", 32'(low_obs), 1);

        // chained mode, start time 100
        wr(0, 1, 7);
        wr(1, 1, 32'hFFFF_FFFF - 32'd100);
        wr(1, 2, 1);
        wr(0, 0, 32'h8);
        wr(1, 0, 32'h1);
        wr(0, 0, 32'hB);
        @(negedge clk);
        check("R6 start time reads T", high_obs, 100);
        check("R3 low reads setting", 32'(low_obs), 7);
        repeat (7) @(negedge clk);
        check("R3 no step before low tc", high_obs, 100);
        @(negedge clk);
        check("R4 one step per low tc", high_obs, 101);
        repeat (40) @(negedge clk);
        check("R4 counts microseconds", high_obs, 106);

        // overflow
        wr(1, 1, 2);
        wr(0, 0, 32'hB);
        @(negedge clk);
        check("R4 inverse of setting", high_obs, 32'hFFFF_FFFD);
        seen = 0;
        prev = high_obs;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (irq_pulse) begin
                seen = 1;
                check("R5 value before wrap", prev, 32'hFFFF_FFFF);
                check("R5 wrap value", high_obs, 32'hFFFF_FFFD);
                check("R7 status set by overflow", 32'(irq_status), 1);
            end
            prev = high_obs;
        end
        check("R5 overflow pulse seen", 32'(seen), 1);
        wr(1, 3, 1);
        check("R7 clear status", 32'(irq_status), 0);

        // standalone high stage
        wr(0, 0, 0);
        wr(1, 2, 0);
        wr(1, 1, 5);
        wr(1, 0, 32'h3);
        @(negedge clk);
        check("R9 raw high count", high_obs, 5);
        @(negedge clk);
        check("R9 high counts down", high_obs, 4);

        // clear colliding with a terminal count
        wr(1, 1, 0);
        wr(1, 0, 32'h3);
        @(negedge clk);
        @(negedge clk);
        wr(1, 3, 1);
        check("R7 set wins over clear", 32'(irq_status), 1);
        wr(1, 0, 0);
        wr(1, 3, 1);
        check("R7 clear after stop", 32'(irq_status), 0);

        // random register traffic
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 4) == 0) begin
                int k;
                logic stg;
                logic [31:0] d;
                k = $urandom % 4;
                stg = 1'($urandom & 1);
                case (k)
                    0: d = $urandom & 32'hB;
                    1: d = (stg && ($urandom & 1)) ? 32'hFFFF_FFFF - ($urandom % 4) : $urandom % 6;
                    2: d = $urandom % 4;
                    default: d = $urandom & 1;
                endcase
                wr(stg, 2'(k), d);
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (100000) @(posedge clk);
                mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule